// File: doc/BRIEF.md
# Video DMA Command Sequencer

This block sits behind the control and data ports of a video controller and turns port writes into DMA work. Control-port words either load one of the DMA registers or, as a two-word pair, form a command holding a target code, a 16-bit destination address and a DMA request bit. When DMA is enabled and a command carries the request bit, the method field picks one of three jobs. A transfer from CPU memory holds the CPU for the transfer time. A copy moves bytes inside video memory. A fill writes one word repeatedly.

Every job announces itself to the downstream write FIFO as a single queue entry, which carries an entry count and a byte-mode flag. Copy and fill drive a simple memory write port, one write per clock. A copy reads its source bytes through a combinational read port. A fill is armed by its command, and only the next data-port write starts it. The word written there becomes the fill value.

A new DMA launched while the previous one is still busy tells the FIFO to discard its pending entries and descriptors. The old job then stops.

Top module: `vdma_sequencer`

## Requirements
- R1: After reset, fifoPush, fifoFlush, dmaBusy, fillPending, cpuHold and memWe are all low.
- R2: A control word with bits 15:14 = 2'b10, when no command word is outstanding, writes register number bits 12:8 with value bits 7:0. Any other control word opens a command, and the next control word closes it.
  - The command's target code is {second[5:4], first[15:14]}, its address is {second[1:0], first[13:0]} and its DMA request bit is second[7].
  - Each data-port write pushes one entry of count 1 in the following cycle and advances the address by the increment register (register 0x0F).
  - Byte mode is set when the target code is 4'b0001.
- R3: While bit 4 of register 0x01 is clear, a command with the request bit set pushes nothing, arms nothing and leaves dmaBusy low.
- R4: Bits 7:6 of register 0x17 select the method: 2'b10 is fill, 2'b11 is copy, and 2'b00 or 2'b01 is transfer from CPU memory.
- R5: A copy pushes one byte-mode entry whose count is the length, taken as {reg 0x14, reg 0x13}.
  - Starting the cycle after that push, it performs one byte write per cycle for as many cycles as the length.
  - Write k reads source address S+k and writes that byte, zero-extended, to destination D+k*inc.
  - S is {reg 0x16, reg 0x15}, D is the command address and inc is register 0x0F.
- R6: A fill command pushes nothing and raises fillPending. The next data-port write clears fillPending and pushes a single entry of count length+1, which covers that write together with the fill.
  - The fill then writes the data word length times, starting at the command address plus inc and stepping by inc.
- R7: A transfer pushes one entry whose count is the length, with byte mode set by the target code. It performs no memory writes.
  - cpuHold rises the cycle after the push and stays high for exactly length+8 cycles.
- R8: Launching a transfer or copy adds the length to the 16-bit source {reg 0x16, reg 0x15}, modulo 2^16, and clears the length registers. A fill changes neither.
- R9: A length of zero is taken as 65536 in both the FIFO count and the job duration.
- R10: Launching a DMA while dmaBusy is high pulses fifoFlush in the cycle of the new launch, and any running memory writes stop one cycle later.
- R11: dmaBusy is high from the cycle after a launch until the job's last write or hold cycle. It is also high while a fill is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWe | input | 1 | Control-port write strobe |
| ctrlData | input | 16 | Control-port word |
| dataWe | input | 1 | Data-port write strobe (ignored when ctrlWe is high) |
| dataWord | input | 16 | Data-port word |
| copyRdData | input | 8 | Byte read at copyRdAddr, same cycle |
| copyRdAddr | output | 16 | Copy source byte address |
| fifoPush | output | 1 | One-cycle queue entry strobe |
| fifoCount | output | 18 | Entry count of the queue entry |
| fifoByte | output | 1 | Queue entry is byte mode |
| fifoFlush | output | 1 | Discard pending FIFO entries and descriptors |
| dmaBusy | output | 1 | DMA launched, armed or running |
| fillPending | output | 1 | Fill armed, waiting for a data write |
| cpuHold | output | 1 | CPU held for a transfer |
| memWe | output | 1 | Fill or copy memory write strobe |
| memByte | output | 1 | Current write is a byte write (copy) |
| memAddr | output | 16 | Write address |
| memData | output | 16 | Write data |

## Verification
The hardest state to reach is an overlap: a second DMA has to be launched while a long job is still writing. The bench gets there by clearing the length registers through a completed copy. It then launches a copy of the implied 65536 bytes and immediately issues a fill command over it. It then checks the flush pulse, that the writes stop one cycle later, and that the armed fill runs on the next data write. The long transfer hold of a zero length is counted to the cycle. The source advance is observed only through the read address of a later copy.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int LEN_W  = 16;
  localparam int ELEN_W = LEN_W + 1;   // effective length, zero means 2^LEN_W
  localparam int CNT_W  = LEN_W + 2;   // FIFO entry count, fill adds one word
  localparam int RNUM_W = 5;

  localparam logic [RNUM_W-1:0] RIX_MODE  = 5'h01;
  localparam logic [RNUM_W-1:0] RIX_INC   = 5'h0F;
  localparam logic [RNUM_W-1:0] RIX_LEN_L = 5'h13;
  localparam logic [RNUM_W-1:0] RIX_LEN_H = 5'h14;
  localparam logic [RNUM_W-1:0] RIX_SRC_L = 5'h15;
  localparam logic [RNUM_W-1:0] RIX_SRC_H = 5'h16;
  localparam logic [RNUM_W-1:0] RIX_METH  = 5'h17;

  localparam int EN_BIT = 4;
  localparam logic [3:0] BYTE_TARGET = 4'b0001;

  typedef enum logic [1:0] {
    KIND_XFER = 2'd0,
    KIND_COPY = 2'd1,
    KIND_FILL = 2'd2
  } kind_t;

  typedef struct packed {
    logic  start;
    logic  abort;
    kind_t kind;
  } dpCmd_t;

  function automatic kind_t decodeMethod(input logic [1:0] m);
    if (m == 2'b10)      return KIND_FILL;
    else if (m == 2'b11) return KIND_COPY;
    else                 return KIND_XFER;
  endfunction
endpackage

// File: rtl/vdma_cmd_ctrl.sv
module vdma_cmd_ctrl
  import vdma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [WORD_W-1:0] ctrlData,
  input  logic              dataWe,
  input  logic [WORD_W-1:0] dataWord,
  input  logic              engBusy,
  output dpCmd_t            dpCmd,
  output logic [ELEN_W-1:0] opLen,
  output logic [WORD_W-1:0] opSrc,
  output logic [WORD_W-1:0] opDest,
  output logic [BYTE_W-1:0] opInc,
  output logic [WORD_W-1:0] opData,
  output logic              fifoPush,
  output logic [CNT_W-1:0]  fifoCount,
  output logic              fifoByte,
  output logic              fifoFlush,
  output logic              fillArm,
  output logic              dmaBusy
);
  logic              wordOpen;
  logic [WORD_W-1:0] cmdHi;
  logic              cmdDmaBit;
  logic [3:0]        cmdCode;
  logic [WORD_W-1:0] cmdAddr;
  logic              dmaEn;
  logic [BYTE_W-1:0] incReg;
  logic [LEN_W-1:0]  lenReg;
  logic [WORD_W-1:0] srcReg;
  logic [1:0]        methodSel;

  logic              isRegWr, isHiWr, isLoWr, dataAct;
  logic              dmaBitEff, launch;
  logic [3:0]        newCode;
  logic [WORD_W-1:0] newAddr, stepAddr;
  logic [ELEN_W-1:0] effLen;
  kind_t             launchKind;

  always_comb begin
    isRegWr    = ctrlWe && !wordOpen && (ctrlData[15:14] == 2'b10);
    isHiWr     = ctrlWe && !wordOpen && (ctrlData[15:14] != 2'b10);
    isLoWr     = ctrlWe && wordOpen;
    dataAct    = dataWe && !ctrlWe;
    dmaBitEff  = dmaEn ? ctrlData[7] : cmdDmaBit;
    newCode    = {ctrlData[5:4], cmdHi[15:14]};
    newAddr    = {ctrlData[1:0], cmdHi[13:0]};
    launch     = isLoWr && dmaBitEff && dmaEn;
    launchKind = decodeMethod(methodSel);
    effLen     = (lenReg == '0) ? ELEN_W'(1) << LEN_W : ELEN_W'(lenReg);
    stepAddr   = cmdAddr + WORD_W'(incReg);
    dmaBusy    = fillArm || dpCmd.start || engBusy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordOpen  <= 1'b0;
      cmdHi     <= '0;
      cmdDmaBit <= 1'b0;
      cmdCode   <= '0;
      cmdAddr   <= '0;
      dmaEn     <= 1'b0;
      incReg    <= '0;
      lenReg    <= '0;
      srcReg    <= '0;
      methodSel <= '0;
      fillArm   <= 1'b0;
      dpCmd     <= '0;
      opLen     <= '0;
      opSrc     <= '0;
      opDest    <= '0;
      opInc     <= '0;
      opData    <= '0;
      fifoPush  <= 1'b0;
      fifoCount <= '0;
      fifoByte  <= 1'b0;
      fifoFlush <= 1'b0;
    end else begin
      fifoPush    <= 1'b0;
      fifoFlush   <= 1'b0;
      dpCmd.start <= 1'b0;
      dpCmd.abort <= 1'b0;
      if (isRegWr) begin
        case (ctrlData[12:8])
          RIX_MODE:  dmaEn          <= ctrlData[EN_BIT];
          RIX_INC:   incReg         <= ctrlData[7:0];
          RIX_LEN_L: lenReg[7:0]    <= ctrlData[7:0];
          RIX_LEN_H: lenReg[15:8]   <= ctrlData[7:0];
          RIX_SRC_L: srcReg[7:0]    <= ctrlData[7:0];
          RIX_SRC_H: srcReg[15:8]   <= ctrlData[7:0];
          RIX_METH:  methodSel      <= ctrlData[7:6];
          default: ;
        endcase
      end else if (isHiWr) begin
        cmdHi    <= ctrlData;
        wordOpen <= 1'b1;
      end else if (isLoWr) begin
        wordOpen  <= 1'b0;
        cmdDmaBit <= dmaBitEff;
        cmdCode   <= newCode;
        cmdAddr   <= newAddr;
        if (launch) begin
          fifoFlush <= dmaBusy;
          if (launchKind == KIND_FILL) begin
            fillArm     <= 1'b1;
            dpCmd.abort <= 1'b1;
          end else begin
            fillArm     <= 1'b0;
            dpCmd.start <= 1'b1;
            dpCmd.kind  <= launchKind;
            opLen       <= effLen;
            opSrc       <= srcReg;
            opDest      <= newAddr;
            opInc       <= incReg;
            fifoPush    <= 1'b1;
            fifoCount   <= CNT_W'(effLen);
            fifoByte    <= (launchKind == KIND_COPY) || (newCode == BYTE_TARGET);
            srcReg      <= srcReg + effLen[LEN_W-1:0];
            lenReg      <= '0;
          end
        end
      end else if (dataAct) begin
        cmdAddr  <= stepAddr;
        fifoPush <= 1'b1;
        fifoByte <= (cmdCode == BYTE_TARGET);
        if (fillArm) begin
          fillArm     <= 1'b0;
          dpCmd.start <= 1'b1;
          dpCmd.kind  <= KIND_FILL;
          opLen       <= effLen;
          opDest      <= stepAddr;
          opInc       <= incReg;
          opData      <= dataWord;
          fifoCount   <= CNT_W'(effLen) + CNT_W'(1);
        end else begin
          fifoCount   <= CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/vdma_engine.sv
module vdma_engine
  import vdma_pkg::*;
#(
  parameter int HOLD_EXTRA = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            dpCmd,
  input  logic [ELEN_W-1:0] opLen,
  input  logic [WORD_W-1:0] opSrc,
  input  logic [WORD_W-1:0] opDest,
  input  logic [BYTE_W-1:0] opInc,
  input  logic [WORD_W-1:0] opData,
  input  logic [BYTE_W-1:0] copyRdData,
  output logic [WORD_W-1:0] copyRdAddr,
  output logic              engBusy,
  output logic              cpuHold,
  output logic              memWe,
  output logic              memByte,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memData
);
  localparam int REM_W = CNT_W;

  logic              active;
  kind_t             kind;
  logic [REM_W-1:0]  remain;
  logic [WORD_W-1:0] dest, src, fillWord;
  logic [BYTE_W-1:0] inc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      kind     <= KIND_XFER;
      remain   <= '0;
      dest     <= '0;
      src      <= '0;
      fillWord <= '0;
      inc      <= '0;
    end else if (dpCmd.start) begin
      active   <= 1'b1;
      kind     <= dpCmd.kind;
      remain   <= (dpCmd.kind == KIND_XFER) ? REM_W'(opLen) + REM_W'(HOLD_EXTRA)
                                            : REM_W'(opLen);
      dest     <= opDest;
      src      <= opSrc;
      fillWord <= opData;
      inc      <= opInc;
    end else if (dpCmd.abort) begin
      active <= 1'b0;
    end else if (active) begin
      remain <= remain - REM_W'(1);
      if (remain == REM_W'(1)) active <= 1'b0;
      if (kind != KIND_XFER) dest <= dest + WORD_W'(inc);
      if (kind == KIND_COPY) src <= src + WORD_W'(1);
    end
  end

  always_comb begin
    engBusy    = active;
    cpuHold    = active && (kind == KIND_XFER);
    memWe      = active && (kind != KIND_XFER);
    memByte    = active && (kind == KIND_COPY);
    memAddr    = dest;
    copyRdAddr = src;
    memData    = (kind == KIND_COPY) ? {{(WORD_W-BYTE_W){1'b0}}, copyRdData} : fillWord;
  end
endmodule

// File: rtl/vdma_sequencer.sv
module vdma_sequencer
  import vdma_pkg::*;
#(
  parameter int HOLD_EXTRA = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [WORD_W-1:0] ctrlData,
  input  logic              dataWe,
  input  logic [WORD_W-1:0] dataWord,
  input  logic [BYTE_W-1:0] copyRdData,
  output logic [WORD_W-1:0] copyRdAddr,
  output logic              fifoPush,
  output logic [CNT_W-1:0]  fifoCount,
  output logic              fifoByte,
  output logic              fifoFlush,
  output logic              dmaBusy,
  output logic              fillPending,
  output logic              cpuHold,
  output logic              memWe,
  output logic              memByte,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memData
);
  dpCmd_t            dpCmd;
  logic [ELEN_W-1:0] opLen;
  logic [WORD_W-1:0] opSrc, opDest, opData;
  logic [BYTE_W-1:0] opInc;
  logic              engBusy;

  vdma_cmd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlData(ctrlData),
    .dataWe(dataWe), .dataWord(dataWord), .engBusy(engBusy),
    .dpCmd(dpCmd), .opLen(opLen), .opSrc(opSrc), .opDest(opDest),
    .opInc(opInc), .opData(opData), .fifoPush(fifoPush),
    .fifoCount(fifoCount), .fifoByte(fifoByte), .fifoFlush(fifoFlush),
    .fillArm(fillPending), .dmaBusy(dmaBusy)
  );

  vdma_engine #(.HOLD_EXTRA(HOLD_EXTRA)) u_eng (
    .clk(clk), .rstN(rstN), .dpCmd(dpCmd), .opLen(opLen), .opSrc(opSrc),
    .opDest(opDest), .opInc(opInc), .opData(opData),
    .copyRdData(copyRdData), .copyRdAddr(copyRdAddr), .engBusy(engBusy),
    .cpuHold(cpuHold), .memWe(memWe), .memByte(memByte),
    .memAddr(memAddr), .memData(memData)
  );
endmodule

// File: rtl/vdma_sequencer_chk.sv
module vdma_sequencer_chk
  import vdma_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             fifoPush,
  input logic [CNT_W-1:0] fifoCount,
  input logic             fifoFlush,
  input logic             dmaBusy,
  input logic             fillPending,
  input logic             cpuHold,
  input logic             memWe,
  input logic             memByte
);
  // R10
  flush_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoFlush |-> dmaBusy);
  // R7
  hold_nowrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuHold |-> !memWe);
  // R7
  hold_after_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuHold) |-> $past(fifoPush));
  // R6
  armed_nowrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fillPending && $past(fillPending)) |-> !memWe);
  // R9
  count_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoPush |-> (fifoCount != '0));
  // R11
  write_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> dmaBusy);
  // R5
  byte_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memByte |-> memWe);
endmodule

bind vdma_sequencer vdma_sequencer_chk u_chk (.*);

// File: tb/tb_vdma_sequencer.sv
module tb_vdma_sequencer;
  logic        clk = 1'b0;
  logic        rstN;
  logic        ctrlWe, dataWe;
  logic [15:0] ctrlData, dataWord;
  logic [7:0]  copyRdData;
  logic [15:0] copyRdAddr, memAddr, memData;
  logic        fifoPush, fifoByte, fifoFlush, dmaBusy, fillPending, cpuHold, memWe, memByte;
  logic [17:0] fifoCount;

  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] romByte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction
  assign copyRdData = romByte(copyRdAddr);

  vdma_sequencer dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctrlWr(input logic [15:0] w);
    ctrlWe = 1'b1; ctrlData = w;
    @(negedge clk);
    ctrlWe = 1'b0;
  endtask

  task automatic regWr(input logic [4:0] n, input logic [7:0] v);
    ctrlWr({3'b100, n, v});
  endtask

  task automatic cmdWr(input logic [15:0] a, input logic [3:0] code, input logic dma);
    ctrlWr({code[1:0], a[13:0]});
    ctrlWr({8'h00, dma, 1'b0, code[3:2], 2'b00, a[15:14]});
  endtask

  task automatic dataWr(input logic [15:0] w);
    dataWe = 1'b1; dataWord = w;
    @(negedge clk);
    dataWe = 1'b0;
  endtask

  task automatic setLen(input logic [15:0] n);
    regWr(5'h13, n[7:0]); regWr(5'h14, n[15:8]);
  endtask

  task automatic setSrc(input logic [15:0] s);
    regWr(5'h15, s[7:0]); regWr(5'h16, s[15:8]);
  endtask

  // caller stands at the first write cycle
  task automatic runWrites(input string req, input int n, input logic [15:0] dest,
                           input logic [7:0] inc, input bit isCopy,
                           input logic [15:0] src, input logic [15:0] data);
    for (int i = 0; i < n; i++) begin
      logic [15:0] ea, es;
      ea = dest + 16'(i) * {8'h00, inc};
      es = src + 16'(i);
      check({req, " write strobe"}, memWe, 1'b1);
      check({req, " write addr"}, memAddr, ea);
      check({req, " byte flag"}, memByte, isCopy);
      if (isCopy) begin
        check({req, " read addr"}, copyRdAddr, es);
        check({req, " copy data"}, memData, {8'h00, romByte(es)});
      end else begin
        check({req, " fill data"}, memData, data);
      end
      @(negedge clk);
    end
    check({req, " writes end"}, memWe, 1'b0);
    check("R11 busy ends", dmaBusy, 1'b0);
  endtask

  task automatic countHold(input int limit, output int hc, output int wc);
    hc = 0; wc = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (cpuHold) hc++;
      if (memWe) wc++;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R11 actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] expSrc, n16, src, dest, d;
    logic [7:0]  inc;
    logic [3:0]  code;
    int n, hc, wc;
    void'($urandom(32'h5EED_0042));
    rstN = 1'b0; ctrlWe = 1'b0; dataWe = 1'b0; ctrlData = '0; dataWord = '0;
    repeat (3) @(negedge clk);
    check("R1 push", fifoPush, 0);
    check("R1 flush", fifoFlush, 0);
    check("R1 busy", dmaBusy, 0);
    check("R1 pending", fillPending, 0);
    check("R1 hold", cpuHold, 0);
    check("R1 write", memWe, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R3: DMA disabled
    regWr(5'h01, 8'h00);
    setLen(16'd5);
    regWr(5'h17, 8'hC0);
    cmdWr(16'h1000, 4'b0001, 1'b1);
    check("R3 no push", fifoPush, 0);
    check("R3 not busy", dmaBusy, 0);
    regWr(5'h17, 8'h80);
    cmdWr(16'h1000, 4'b0001, 1'b1);
    check("R3 no fill arm", fillPending, 0);
    @(negedge clk);
    check("R3 no write", memWe, 0);
    regWr(5'h01, 8'h10);

    // R2: plain data writes
    regWr(5'h0F, 8'd2);
    cmdWr(16'h0040, 4'b0001, 1'b0);
    check("R2 command without dma", fifoPush, 0);
    dataWr(16'h1234);
    check("R2 data push", fifoPush, 1);
    check("R2 data count", fifoCount, 1);
    check("R2 byte target", fifoByte, 1);
    cmdWr(16'h0020, 4'b0011, 1'b0);
    dataWr(16'h5678);
    check("R2 word target", fifoByte, 0);

    // R5: random copies
    for (int k = 0; k < 4; k++) begin
      n = 1 + int'($urandom % 10);
      src = 16'($urandom); dest = 16'($urandom); inc = 8'($urandom);
      setLen(16'(n)); setSrc(src); regWr(5'h17, 8'hC0); regWr(5'h0F, inc);
      cmdWr(dest, 4'b0011, 1'b1);
      check("R5 push", fifoPush, 1);
      check("R5 count", fifoCount, n);
      check("R5 byte entry", fifoByte, 1);
      check("R10 no flush when idle", fifoFlush, 0);
      check("R11 busy at launch", dmaBusy, 1);
      @(negedge clk);
      runWrites("R5 copy", n, dest, inc, 1'b1, src, 16'h0);
      expSrc = src + 16'(n);
    end

    // R8: source advanced by previous copy
    setLen(16'd3);
    cmdWr(16'h2000, 4'b0001, 1'b1);
    @(negedge clk);
    check("R8 source advanced", copyRdAddr, expSrc);
    runWrites("R8 copy", 3, 16'h2000, inc, 1'b1, expSrc, 16'h0);
    expSrc = expSrc + 16'd3;

    // R8/R9: length cleared -> 65536, then R10 overlap
    cmdWr(16'h3000, 4'b0001, 1'b1);
    check("R8 length cleared count", fifoCount, 18'h10000);
    @(negedge clk);
    check("R9 long copy writing", memWe, 1);
    regWr(5'h17, 8'h80);
    regWr(5'h0F, 8'd3);
    cmdWr(16'h4000, 4'b0001, 1'b1);
    check("R10 flush on overlap", fifoFlush, 1);
    check("R6 fill command pushes nothing", fifoPush, 0);
    check("R6 fill armed", fillPending, 1);
    @(negedge clk);
    check("R10 old copy stopped", memWe, 0);
    check("R11 busy while armed", dmaBusy, 1);

    // R6: fill triggered by next data write
    setLen(16'd4);
    dataWr(16'hBEEF);
    check("R6 trigger push", fifoPush, 1);
    check("R6 merged count", fifoCount, 5);
    check("R6 byte target", fifoByte, 1);
    check("R6 pending cleared", fillPending, 0);
    @(negedge clk);
    runWrites("R6 fill", 4, 16'h4003, 8'd3, 1'b0, 16'h0, 16'hBEEF);
    for (int k = 0; k < 2; k++) begin
      n = 1 + int'($urandom % 8);
      dest = 16'($urandom); inc = 8'($urandom); d = 16'($urandom);
      regWr(5'h0F, inc);
      cmdWr(dest, 4'b0011, 1'b1);
      check("R6 random arm", fillPending, 1);
      setLen(16'(n));
      dataWr(d);
      check("R6 random count", fifoCount, n + 1);
      check("R6 word target", fifoByte, 0);
      @(negedge clk);
      runWrites("R6 random fill", n, dest + {8'h00, inc}, inc, 1'b0, 16'h0, d);
    end

    // R8: fill leaves source untouched
    setLen(16'd2); regWr(5'h17, 8'hC0); regWr(5'h0F, 8'd1);
    cmdWr(16'h5000, 4'b0001, 1'b1);
    @(negedge clk);
    check("R8 fill kept source", copyRdAddr, expSrc);
    runWrites("R8 copy after fill", 2, 16'h5000, 8'd1, 1'b1, expSrc, 16'h0);
    expSrc = expSrc + 16'd2;

    // R7/R4: transfers with methods 00 and 01
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < 2; k++) begin
        n = 1 + int'($urandom % 20);
        code = k[0] ? 4'b0011 : 4'b0001;
        setLen(16'(n)); regWr(5'h17, {m[1:0], 6'h2A});
        cmdWr(16'($urandom), code, 1'b1);
        check("R4 transfer push", fifoPush, 1);
        check("R7 transfer count", fifoCount, n);
        check("R7 transfer byte flag", fifoByte, code == 4'b0001);
        countHold(n + 20, hc, wc);
        check("R7 hold length", hc, n + 8);
        check("R7 no writes", wc, 0);
        check("R11 busy after hold", dmaBusy, 0);
        expSrc = expSrc + 16'(n);
      end
    end

    // R9: zero length transfer
    setLen(16'd0); regWr(5'h17, 8'h00);
    cmdWr(16'h0100, 4'b0001, 1'b1);
    check("R9 zero length count", fifoCount, 18'h10000);
    countHold(65560, hc, wc);
    check("R9 zero length hold", hc, 65544);

    // R8: source after transfers (65536 wraps)
    n16 = 16'd1;
    setLen(n16); regWr(5'h17, 8'hC0);
    cmdWr(16'h0200, 4'b0001, 1'b1);
    @(negedge clk);
    check("R8 source after transfers", copyRdAddr, expSrc);
    runWrites("R8 final copy", 1, 16'h0200, 8'd1, 1'b1, expSrc, 16'h0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule